// File: doc/BRIEF.md
# Log Consumer Ordering Gate

This block sits between a log decoder and the event handler of one monitoring thread. Each decoded record may carry a cross-thread ordering arc naming a producer core and an event count. The block passes such a record on only once the shared progress table shows that the named core's event has already been handled elsewhere. Records without an arc go straight through.

The progress table is an ordinary memory region. It holds one counter per application core, each padded to its own 64-byte line. A base register locates the table. To test an arc the block reads the named core's line. If the value is too small it reads again until the value is large enough. After every delivery the block writes the delivered record's own count into its own line, and only then takes the next record. Records leave in the order they arrived, so a record that is waiting holds back every record behind it.

Top module: `dep_enforce_unit`

## Requirements
- R1: After reset, `rec_ready` is 1 and both `dlv_valid` and `mem_req` are 0.
- R2: A record accepted with `rec_has_arc`=0 is presented on `dlv_valid`/`dlv_payload` without any memory read being issued for it.
- R3: For a record with an arc, the block reads address `base + rec_arc_core*64`, with `mem_we`=0. `base` is the last value written through `base_we`, with its low 6 bits forced to zero.
- R4: An arc record is delivered only when the value read back is strictly greater than `rec_arc_count`. When the value is equal or smaller, the block issues another read of the same entry and does not deliver.
- R5: After each delivery, the block writes the record's `rec_seq` to `base + self_idx*64` with `mem_we`=1. `rec_ready` stays 0 until that write is granted.
- R6: Records are delivered in acceptance order. While any record is held, `rec_ready` is 0, so a stalled record blocks all later records.
- R7: While `dlv_valid` is 1 and `dlv_ready` is 0, `dlv_valid` stays 1 and `dlv_payload` does not change.
- R8: While `mem_req` is 1 and `mem_gnt` is 0, `mem_req`, `mem_we` and `mem_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | ADDR_W | New table base address; the low 6 bits are ignored |
| self_idx | input | CORE_W | Index of the application core whose events this consumer handles |
| rec_valid | input | 1 | Decoded record available |
| rec_ready | output | 1 | Block can accept a record |
| rec_has_arc | input | 1 | The record carries an ordering arc |
| rec_arc_core | input | CORE_W | Producer core named by the arc |
| rec_arc_count | input | CNT_W | Event count named by the arc |
| rec_seq | input | CNT_W | The record's own event count, published after delivery |
| rec_payload | input | PAYLOAD_W | Record contents passed to the handler |
| dlv_valid | output | 1 | Record offered to the handler |
| dlv_ready | input | 1 | Handler takes the record |
| dlv_payload | output | PAYLOAD_W | Record contents for the handler |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | CNT_W | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | CNT_W | Read data |

## Verification
The hardest case to reach is a record that waits on an entry holding exactly the arc count. A second record stands behind it in the queue, and a correct design must keep re-reading and must neither deliver nor accept. The bench sets another core's table entry to that exact count and queues an arc record and then an arc-free record. It confirms that reads keep coming while both records stay inside. Only then does it raise the entry by one and check that the two records come out in their original order. Grant withholding on reads and on the publishing write reaches the request-hold and publish-before-accept cases.

// File: rtl/dep_pkg.sv
package dep_pkg;

    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_NUM_CORES  = 16;
    localparam int DEF_CNT_W      = 32;
    localparam int DEF_PAYLOAD_W  = 16;
    localparam int DEF_LINE_BYTES = 64;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_WAIT = 3'd2,
        ST_DELIVER = 3'd3,
        ST_PUBLISH = 3'd4
    } dep_state_e;

    // target selector for the two table addresses the block forms
    typedef enum logic {
        TGT_PEER = 1'b0,
        TGT_SELF = 1'b1
    } dep_tgt_e;

    function automatic logic state_uses_mem(input dep_state_e s);
        return (s == ST_RD_REQ) || (s == ST_PUBLISH);
    endfunction

endpackage

// File: rtl/dep_base_reg.sv
module dep_base_reg #(
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic [ADDR_W-1:0] base_q
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << LINE_SHIFT) - 64'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (base_we) begin
            base_q <= base_wdata & ~LOW_MASK;
        end
    end
endmodule

// File: rtl/dep_addr_gen.sv
module dep_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int CORE_W     = 4,
    parameter int LINE_SHIFT = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CORE_W-1:0] core_idx,
    output logic [ADDR_W-1:0] entry_addr
);
    logic [ADDR_W-1:0] idx_wide;

    always_comb begin
        idx_wide   = ADDR_W'(core_idx);
        entry_addr = base + (idx_wide << LINE_SHIFT);
    end
endmodule

// File: rtl/dep_cmp.sv
module dep_cmp #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] progress,
    input  logic [CNT_W-1:0] need,
    output logic             satisfied
);
    always_comb begin
        satisfied = (progress > need);
    end
endmodule

// File: rtl/dep_seq_ctrl.sv
module dep_seq_ctrl
    import dep_pkg::*;
#(
    parameter int CORE_W    = 4,
    parameter int CNT_W     = 32,
    parameter int PAYLOAD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rec_valid,
    output logic                 rec_ready,
    input  logic                 rec_has_arc,
    input  logic [CORE_W-1:0]    rec_arc_core,
    input  logic [CNT_W-1:0]     rec_arc_count,
    input  logic [CNT_W-1:0]     rec_seq,
    input  logic [PAYLOAD_W-1:0] rec_payload,
    output logic                 dlv_valid,
    input  logic                 dlv_ready,
    output logic [PAYLOAD_W-1:0] dlv_payload,
    output logic                 mem_req,
    output dep_tgt_e             mem_tgt,
    output logic [CNT_W-1:0]     mem_wdata,
    input  logic                 mem_gnt,
    input  logic                 mem_rvalid,
    input  logic                 progress_ok,
    output logic [CORE_W-1:0]    arc_core,
    output logic [CNT_W-1:0]     arc_need
);
    dep_state_e state_q, state_d;

    logic [CORE_W-1:0]    hold_core_q;
    logic [CNT_W-1:0]     hold_need_q;
    logic [CNT_W-1:0]     hold_seq_q;
    logic [PAYLOAD_W-1:0] hold_pay_q;

    logic accept;

    always_comb begin
        accept  = (state_q == ST_IDLE) && rec_valid;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (rec_valid)  state_d = rec_has_arc ? ST_RD_REQ : ST_DELIVER;
            ST_RD_REQ:  if (mem_gnt)    state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rvalid) state_d = progress_ok ? ST_DELIVER : ST_RD_REQ;
            ST_DELIVER: if (dlv_ready)  state_d = ST_PUBLISH;
            ST_PUBLISH: if (mem_gnt)    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            hold_core_q <= '0;
            hold_need_q <= '0;
            hold_seq_q  <= '0;
            hold_pay_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                hold_core_q <= rec_arc_core;
                hold_need_q <= rec_arc_count;
                hold_seq_q  <= rec_seq;
                hold_pay_q  <= rec_payload;
            end
        end
    end

    always_comb begin
        rec_ready   = (state_q == ST_IDLE);
        dlv_valid   = (state_q == ST_DELIVER);
        dlv_payload = hold_pay_q;
        mem_req     = state_uses_mem(state_q);
        mem_tgt     = (state_q == ST_PUBLISH) ? TGT_SELF : TGT_PEER;
        mem_wdata   = hold_seq_q;
        arc_core    = hold_core_q;
        arc_need    = hold_need_q;
    end
endmodule

// File: rtl/dep_enforce_unit.sv
module dep_enforce_unit
    import dep_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int NUM_CORES  = DEF_NUM_CORES,
    parameter int CNT_W      = DEF_CNT_W,
    parameter int PAYLOAD_W  = DEF_PAYLOAD_W,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    localparam int CORE_W     = $clog2(NUM_CORES),
    localparam int LINE_SHIFT = $clog2(LINE_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 base_we,
    input  logic [ADDR_W-1:0]    base_wdata,
    input  logic [CORE_W-1:0]    self_idx,
    input  logic                 rec_valid,
    output logic                 rec_ready,
    input  logic                 rec_has_arc,
    input  logic [CORE_W-1:0]    rec_arc_core,
    input  logic [CNT_W-1:0]     rec_arc_count,
    input  logic [CNT_W-1:0]     rec_seq,
    input  logic [PAYLOAD_W-1:0] rec_payload,
    output logic                 dlv_valid,
    input  logic                 dlv_ready,
    output logic [PAYLOAD_W-1:0] dlv_payload,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [CNT_W-1:0]     mem_wdata,
    input  logic                 mem_gnt,
    input  logic                 mem_rvalid,
    input  logic [CNT_W-1:0]     mem_rdata
);
    localparam int NUM_TGT = 2;

    logic [ADDR_W-1:0] base_q;
    logic [CORE_W-1:0] arc_core;
    logic [CNT_W-1:0]  arc_need;
    logic              progress_ok;
    dep_tgt_e          mem_tgt;

    logic [CORE_W-1:0] tgt_core [NUM_TGT];
    logic [ADDR_W-1:0] tgt_addr [NUM_TGT];

    dep_base_reg #(
        .ADDR_W     (ADDR_W),
        .LINE_SHIFT (LINE_SHIFT)
    ) u_base (
        .clk        (clk),
        .rst        (rst),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .base_q     (base_q)
    );

    assign tgt_core[TGT_PEER] = arc_core;
    assign tgt_core[TGT_SELF] = self_idx;

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        dep_addr_gen #(
            .ADDR_W     (ADDR_W),
            .CORE_W     (CORE_W),
            .LINE_SHIFT (LINE_SHIFT)
        ) u_addr (
            .base       (base_q),
            .core_idx   (tgt_core[g]),
            .entry_addr (tgt_addr[g])
        );
    end

    dep_cmp #(
        .CNT_W     (CNT_W)
    ) u_cmp (
        .progress  (mem_rdata),
        .need      (arc_need),
        .satisfied (progress_ok)
    );

    dep_seq_ctrl #(
        .CORE_W        (CORE_W),
        .CNT_W         (CNT_W),
        .PAYLOAD_W     (PAYLOAD_W)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .rec_valid     (rec_valid),
        .rec_ready     (rec_ready),
        .rec_has_arc   (rec_has_arc),
        .rec_arc_core  (rec_arc_core),
        .rec_arc_count (rec_arc_count),
        .rec_seq       (rec_seq),
        .rec_payload   (rec_payload),
        .dlv_valid     (dlv_valid),
        .dlv_ready     (dlv_ready),
        .dlv_payload   (dlv_payload),
        .mem_req       (mem_req),
        .mem_tgt       (mem_tgt),
        .mem_wdata     (mem_wdata),
        .mem_gnt       (mem_gnt),
        .mem_rvalid    (mem_rvalid),
        .progress_ok   (progress_ok),
        .arc_core      (arc_core),
        .arc_need      (arc_need)
    );

    always_comb begin
        mem_we   = (mem_tgt == TGT_SELF);
        mem_addr = tgt_addr[mem_tgt];
    end
endmodule

// File: rtl/dep_enforce_chk.sv
module dep_enforce_chk #(
    parameter int ADDR_W     = 32,
    parameter int PAYLOAD_W  = 16,
    parameter int LINE_SHIFT = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rec_ready,
    input logic                 dlv_valid,
    input logic                 dlv_ready,
    input logic [PAYLOAD_W-1:0] dlv_payload,
    input logic                 mem_req,
    input logic                 mem_we,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic                 mem_gnt
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (rec_ready && !dlv_valid && !mem_req)); // R1

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[LINE_SHIFT-1:0] == '0)); // R3

    AST_PUBLISH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && dlv_ready) |=> (mem_req && mem_we && !rec_ready)); // R5

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (mem_req || dlv_valid) |-> !rec_ready); // R6

    AST_DLV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_payload))); // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R8
endmodule

bind dep_enforce_unit dep_enforce_chk #(
    .ADDR_W     (ADDR_W),
    .PAYLOAD_W  (PAYLOAD_W),
    .LINE_SHIFT (LINE_SHIFT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rec_ready   (rec_ready),
    .dlv_valid   (dlv_valid),
    .dlv_ready   (dlv_ready),
    .dlv_payload (dlv_payload),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_gnt     (mem_gnt)
);

// File: tb/dep_enforce_unit_bench.sv
module dep_enforce_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int NUM_CORES = 16;
    localparam int CORE_W = 4;
    localparam int CNT_W = 32;
    localparam int PW = 16;
    localparam logic [CORE_W-1:0] SELF = 4'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic base_we = 1'b0;
    logic [ADDR_W-1:0] base_wdata = '0;
    logic rec_valid = 1'b0;
    logic rec_ready;
    logic rec_has_arc = 1'b0;
    logic [CORE_W-1:0] rec_arc_core = '0;
    logic [CNT_W-1:0] rec_arc_count = '0;
    logic [CNT_W-1:0] rec_seq = '0;
    logic [PW-1:0] rec_payload = '0;
    logic dlv_valid;
    logic dlv_ready = 1'b1;
    logic [PW-1:0] dlv_payload;
    logic mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [CNT_W-1:0] mem_wdata;
    logic mem_gnt;
    logic gnt_en = 1'b1;
    logic mem_rvalid = 1'b0;
    logic [CNT_W-1:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_gnt = mem_req & gnt_en;

    dep_enforce_unit u_dep_enforce_unit (
        .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
        .self_idx(SELF), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_has_arc(rec_has_arc), .rec_arc_core(rec_arc_core),
        .rec_arc_count(rec_arc_count), .rec_seq(rec_seq), .rec_payload(rec_payload),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_payload(dlv_payload),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // scoreboard state
    logic [PW-1:0] exp_pay_q [$];
    logic [ADDR_W+CNT_W-1:0] exp_wr_q [$];
    logic [ADDR_W-1:0] base_exp = '0;

    int main_pass = 0, main_fail = 0;
    int mon_pass = 0, mon_fail = 0;
    int mem_pass = 0, mem_fail = 0;
    int mon_deliv = 0;
    int rd_count = 0;
    logic [ADDR_W-1:0] last_rd_addr = '0;

    // table access from the stimulus side
    logic ext_we = 1'b0;
    logic [CORE_W-1:0] ext_idx = '0;
    logic [CNT_W-1:0] ext_val = '0;
    logic [CNT_W-1:0] table_q [NUM_CORES];

    // memory model: one-cycle read latency, writes checked against scoreboard
    always @(posedge clk) begin
        logic [ADDR_W-1:0] off;
        logic [ADDR_W+CNT_W-1:0] ew;
        off = (mem_addr - base_exp) >> 6;
        if (rst) begin
            for (int k = 0; k < NUM_CORES; k++) table_q[k] <= '0;
            mem_rvalid <= 1'b0;
        end else begin
            mem_rvalid <= 1'b0;
            if (ext_we) table_q[ext_idx] <= ext_val;
            if (mem_req && mem_gnt && !mem_we) begin
                mem_rvalid   <= 1'b1;
                mem_rdata    <= table_q[off[CORE_W-1:0]];
                rd_count     <= rd_count + 1;
                last_rd_addr <= mem_addr;
            end
            if (mem_req && mem_gnt && mem_we) begin
                if (exp_wr_q.size() == 0) begin
                    mem_fail++;
                    $display("FAIL R5 unexpected write actual addr=%h data=%0d expected none", mem_addr, mem_wdata);
                end else begin
                    ew = exp_wr_q.pop_front();
                    if ({mem_addr, mem_wdata} === ew) mem_pass++;
                    else begin
                        mem_fail++;
                        $display("FAIL R5 publish actual addr=%h data=%0d expected addr=%h data=%0d",
                                 mem_addr, mem_wdata, ew[ADDR_W+CNT_W-1:CNT_W], ew[CNT_W-1:0]);
                    end
                end
                table_q[off[CORE_W-1:0]] <= mem_wdata;
            end
        end
    end

    // delivery monitor: order (R6, R2, R4) and hold (R7)
    logic stall_seen = 1'b0;
    logic [PW-1:0] stall_pay = '0;
    always @(negedge clk) begin
        logic [PW-1:0] e;
        if (!rst) begin
            if (stall_seen) begin
                if (dlv_valid && dlv_payload == stall_pay) mon_pass++;
                else begin
                    mon_fail++;
                    $display("FAIL R7 hold actual valid=%b pay=%h expected valid=1 pay=%h", dlv_valid, dlv_payload, stall_pay);
                end
            end
            stall_seen = dlv_valid && !dlv_ready;
            stall_pay  = dlv_payload;
            if (dlv_valid && dlv_ready) begin
                mon_deliv++;
                if (exp_pay_q.size() == 0) begin
                    mon_fail++;
                    $display("FAIL R6 unexpected delivery actual=%h expected none", dlv_payload);
                end else begin
                    e = exp_pay_q.pop_front();
                    if (dlv_payload === e) mon_pass++;
                    else begin
                        mon_fail++;
                        $display("FAIL R6 order actual=%h expected=%h", dlv_payload, e);
                    end
                end
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        if (ok) main_pass++;
        else begin
            main_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_entry(input logic [CORE_W-1:0] idx, input logic [CNT_W-1:0] v);
        @(negedge clk);
        ext_we = 1'b1; ext_idx = idx; ext_val = v;
        @(negedge clk);
        ext_we = 1'b0;
    endtask

    task automatic write_base(input logic [ADDR_W-1:0] v);
        @(negedge clk);
        base_we = 1'b1; base_wdata = v;
        @(negedge clk);
        base_we = 1'b0;
        base_exp = v & ~32'h3F;
    endtask

    // driver: waits for acceptance, pushes expected delivery and publish
    task automatic send_rec(input logic arc, input logic [CORE_W-1:0] core,
                            input logic [CNT_W-1:0] need, input logic [CNT_W-1:0] seq,
                            input logic [PW-1:0] pay);
        @(negedge clk);
        rec_valid = 1'b1; rec_has_arc = arc; rec_arc_core = core;
        rec_arc_count = need; rec_seq = seq; rec_payload = pay;
        while (!rec_ready) @(negedge clk);
        exp_pay_q.push_back(pay);
        exp_wr_q.push_back({base_exp + (32'(SELF) << 6), seq});
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    task automatic wait_deliv(input int n);
        for (int k = 0; k < 300 && mon_deliv < n; k++) @(negedge clk);
    endtask

    task automatic summary(input int extra_fail);
        int p, f;
        p = main_pass + mon_pass + mem_pass;
        f = main_fail + mon_fail + mem_fail + extra_fail;
        $display("%0d/%0d checks passed", p, p + f);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=completion");
        summary(1);
        $finish;
    end

    initial begin
        int d0, r0;
        logic [ADDR_W-1:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rec_ready === 1'b1, "R1 rec_ready", 64'(rec_ready), 64'd1);
        chk(dlv_valid === 1'b0, "R1 dlv_valid", 64'(dlv_valid), 64'd0);
        chk(mem_req === 1'b0, "R1 mem_req", 64'(mem_req), 64'd0);

        write_base(32'h1000_0025);

        // R2 arc-free record: no read issued
        r0 = rd_count;
        send_rec(1'b0, 4'd9, 32'd99, 32'd5, 16'h0011);
        wait_deliv(1);
        repeat (3) @(negedge clk);
        chk(mon_deliv == 1, "R2 delivered", 64'(mon_deliv), 64'd1);
        chk(rd_count == r0, "R2 no read", 64'(rd_count), 64'(r0));

        // R3/R4 satisfied arc, read address from aligned base
        set_entry(4'd7, 32'd10);
        send_rec(1'b1, 4'd7, 32'd9, 32'd6, 16'h0022);
        wait_deliv(2);
        chk(mon_deliv == 2, "R4 delivered when greater", 64'(mon_deliv), 64'd2);
        chk(last_rd_addr == 32'h1000_01C0, "R3 read addr", 64'(last_rd_addr), 64'h1000_01C0);

        // R4/R6 equal value stalls, later record blocked behind it
        repeat (3) @(negedge clk);
        set_entry(4'd2, 32'd20);
        d0 = mon_deliv;
        r0 = rd_count;
        send_rec(1'b1, 4'd2, 32'd20, 32'd7, 16'h0033);
        fork
            send_rec(1'b0, 4'd0, 32'd0, 32'd8, 16'h0044);
        join_none
        repeat (20) @(negedge clk);
        chk(mon_deliv == d0, "R4 equal not delivered", 64'(mon_deliv), 64'(d0));
        chk(rd_count >= r0 + 2, "R4 reread", 64'(rd_count), 64'(r0 + 2));
        chk(rec_ready === 1'b0, "R6 blocked", 64'(rec_ready), 64'd0);
        chk(last_rd_addr == 32'h1000_0080, "R3 peer addr", 64'(last_rd_addr), 64'h1000_0080);
        set_entry(4'd2, 32'd21);
        wait_deliv(d0 + 2);
        chk(mon_deliv == d0 + 2, "R6 both delivered", 64'(mon_deliv), 64'(d0 + 2));

        // R7 handler back-pressure
        repeat (4) @(negedge clk);
        dlv_ready = 1'b0;
        send_rec(1'b0, 4'd0, 32'd0, 32'd9, 16'h0055);
        repeat (5) @(negedge clk);
        chk(dlv_valid === 1'b1 && dlv_payload == 16'h0055, "R7 offered", 64'(dlv_payload), 64'h0055);
        d0 = mon_deliv;
        dlv_ready = 1'b1;
        wait_deliv(d0 + 1);

        // R8 read held without grant
        repeat (4) @(negedge clk);
        set_entry(4'd1, 32'd1);
        gnt_en = 1'b0;
        d0 = mon_deliv;
        send_rec(1'b1, 4'd1, 32'd0, 32'd10, 16'h0066);
        repeat (2) @(negedge clk);
        held = mem_addr;
        repeat (4) @(negedge clk);
        chk(mem_req === 1'b1 && mem_we === 1'b0, "R8 req held", 64'({mem_req, mem_we}), 64'b10);
        chk(mem_addr == held && held == 32'h1000_0040, "R8 addr held", 64'(mem_addr), 64'h1000_0040);
        gnt_en = 1'b1;
        wait_deliv(d0 + 1);

        // R5 publish write gates acceptance
        repeat (4) @(negedge clk);
        gnt_en = 1'b0;
        d0 = mon_deliv;
        send_rec(1'b0, 4'd0, 32'd0, 32'd11, 16'h0077);
        wait_deliv(d0 + 1);
        @(negedge clk);
        chk(mem_req === 1'b1 && mem_we === 1'b1, "R5 write pending", 64'({mem_req, mem_we}), 64'b11);
        chk(rec_ready === 1'b0, "R5 no accept", 64'(rec_ready), 64'd0);
        chk(mem_addr == 32'h1000_00C0 && mem_wdata == 32'd11, "R5 own entry",
            {32'(mem_addr), 32'(mem_wdata)}, {32'h1000_00C0, 32'd11});
        gnt_en = 1'b1;

        // R3 new base used
        repeat (4) @(negedge clk);
        write_base(32'h2000_0000);
        set_entry(4'd5, 32'd1);
        d0 = mon_deliv;
        send_rec(1'b1, 4'd5, 32'd0, 32'd12, 16'h0088);
        wait_deliv(d0 + 1);
        chk(last_rd_addr == 32'h2000_0140, "R3 rebased addr", 64'(last_rd_addr), 64'h2000_0140);

        repeat (6) @(negedge clk);
        chk(exp_pay_q.size() == 0, "R6 all delivered", 64'(exp_pay_q.size()), 64'd0);
        chk(exp_wr_q.size() == 0, "R5 all published", 64'(exp_wr_q.size()), 64'd0);
        summary(0);
        $finish;
    end
endmodule